// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer driven through four 32-bit registers on a simple select/enable/write bus. Software writes a control word and a timing word and then restarts the counter at regular intervals. If the restarts stop, a prescaled down-counter reaches zero. The block then latches a status flag. It can also hold a level interrupt and emit one reset request pulse of a programmable length.

Every control write must carry a per-register key in the upper bits of the write data. A write with a wrong key changes nothing. A restart takes effect only when the write data is exactly the restart word. The reload value is coarse: a 12-bit field shifted left by `RELOAD_SHIFT` bits (12 by default). A write commits on a rising edge where select, enable and write are all high. Read data is combinational from the address while select is high.

Top module: `keyed_wdog`

## Requirements
- R1: After reset the mode register reads 0, the timing register reads 0x00003FFF (reload field 0xFFF, prescale select 3), the restart and status registers read 0, and both outputs are low.
- R2: A write to offset 0x0 is taken only when data bits [23:12] equal 0xABC; otherwise the register keeps its value. It stores bit 0 run enable, bit 1 reset-request enable, bit 2 interrupt enable and bits [6:4] pulse code. It reads back with all other bits zero.
- R3: A write to offset 0x4 is taken only when data bits [25:14] equal 0x248; otherwise the register keeps its value. It stores bits [13:2] reload field and bits [1:0] prescale select. It reads back with all other bits zero.
- R4: A write of exactly 0x00001999 to offset 0x8 reloads the counter, restarts the prescaler and clears the status flag. Any other value written there has no effect. Offset 0x8 reads as zero.
- R5: A restart loads the counter with the reload field shifted left by RELOAD_SHIFT. While run is enabled, expiry happens on the rising edge that is field × 2^RELOAD_SHIFT × divisor cycles after the restart edge.
- R6: Prescale select 0, 1, 2 and 3 divide the clock by 8, 64, 512 and 4096.
- R7: The counter and prescaler advance only while run enable is set. Clearing it stops counting at once, and no expiry follows however long the block waits.
- R8: Expiry sets status bit 0 (offset 0xC). The bit stays set until a valid restart.
- R9: The interrupt output equals the status flag AND the interrupt enable.
- R10: At expiry with reset-request enable set, one pulse is emitted that starts on the expiry edge. Its length is 2, 4, 8 or 16 cycles for pulse codes 0, 1, 2 and 3; codes 4 to 7 give 16 cycles.
- R11: With reset-request enable clear, expiry produces no pulse.
- R12: A valid restart that lands on the same edge as an expiry wins: no status, interrupt or pulse results, and a full new period starts from that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte offset; bits [3:2] pick the register |
| pwdata | input | 32 | Write data including key field |
| prdata | output | 32 | Read data, zero while not selected |
| irq_o | output | 1 | Level interrupt on expiry |
| rst_req_o | output | 1 | Reset request pulse on expiry |

## Verification
A restart write and the last prescaler tick can land on the same rising edge. This is the one place where the counter's own expiry competes with a register write. The bench counts cycles from a known restart edge and issues a second restart timed to land exactly on the edge where the count would reach zero. It then requires that the interrupt, the status flag and the reset pulse all stay low, and that the next expiry comes one full period after the colliding edge.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int FIELD_W = 12;
  localparam logic [11:0] MODE_KEY = 12'hABC;
  localparam logic [11:0] TIME_KEY = 12'h248;
  localparam logic [31:0] KICK_WORD = 32'h0000_1999;
  localparam logic [1:0] REG_MODE = 2'd0;
  localparam logic [1:0] REG_TIME = 2'd1;
  localparam logic [1:0] REG_KICK = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  typedef struct packed {
    logic [2:0] pcode;
    logic       irq_en;
    logic       req_en;
    logic       run;
  } mode_t;

  typedef struct packed {
    logic [FIELD_W-1:0] field;
    logic [1:0]         psel;
  } timing_t;
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [3:0]  paddr,
  input  logic [31:0] pwdata,
  input  logic        expired,
  output mode_t       mode_q,
  output timing_t     time_q,
  output logic        kick,
  output logic [31:0] prdata
);
  logic       wr_cyc;
  logic [1:0] rsel;
  logic       mode_hit;
  logic       time_hit;

  assign wr_cyc   = psel & penable & pwrite;
  assign rsel     = paddr[3:2];
  assign mode_hit = wr_cyc && rsel == REG_MODE && pwdata[23:12] == MODE_KEY;
  assign time_hit = wr_cyc && rsel == REG_TIME && pwdata[25:14] == TIME_KEY;
  assign kick     = wr_cyc && rsel == REG_KICK && pwdata == KICK_WORD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      time_q <= '{field: {FIELD_W{1'b1}}, psel: 2'b11};
    end else begin
      if (mode_hit) begin
        mode_q <= '{pcode: pwdata[6:4], irq_en: pwdata[2],
                    req_en: pwdata[1], run: pwdata[0]};
      end
      if (time_hit) begin
        time_q <= '{field: pwdata[FIELD_W+1:2], psel: pwdata[1:0]};
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (rsel)
        REG_MODE: prdata = {25'd0, mode_q.pcode, 1'b0, mode_q.irq_en,
                            mode_q.req_en, mode_q.run};
        REG_TIME: prdata = {{(30-FIELD_W){1'b0}}, time_q.field, time_q.psel};
        REG_STAT: prdata = {31'd0, expired};
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PRE_W = BASE_SHIFT + 3 * STEP_SHIFT;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] limit;
  logic [5:0]       sh;

  // divisor is 2^(BASE + STEP*sel); limit is divisor - 1
  always_comb begin
    sh    = 6'(BASE_SHIFT) + 6'(STEP_SHIFT) * {4'd0, sel};
    limit = {PRE_W{1'b1}} >> (6'(PRE_W) - sh);
  end

  assign tick = run && !clr && pre_q == limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre_q <= '0;
    else if (!run || clr)     pre_q <= '0;
    else if (pre_q == limit)  pre_q <= '0;
    else                      pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
  parameter int FIELD_W = 12,
  parameter int SHIFT   = 12,
  parameter logic [FIELD_W-1:0] RST_FIELD = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     tick,
  input  logic                     kick,
  input  logic [FIELD_W-1:0]       field,
  output logic [FIELD_W+SHIFT-1:0] cnt_q,
  output logic                     expired_q,
  output logic                     expire_evt
);
  localparam int CNT_W = FIELD_W + SHIFT;

  logic [CNT_W-1:0] reload;
  logic             last;

  assign reload     = CNT_W'(field) << SHIFT;
  assign last       = cnt_q <= CNT_W'(1);
  assign expire_evt = run && tick && !expired_q && !kick && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= CNT_W'(RST_FIELD) << SHIFT;
      expired_q <= 1'b0;
    end else if (kick) begin
      cnt_q     <= reload;
      expired_q <= 1'b0;
    end else if (run && tick && !expired_q) begin
      if (last) begin
        cnt_q     <= '0;
        expired_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
  parameter int LEN_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic [2:0] code,
  output logic       pulse
);
  logic [LEN_W-1:0] left_q;
  logic [1:0]       expo;
  logic [LEN_W-1:0] len;

  assign expo  = (code > 3'd3) ? 2'd3 : code[1:0];
  assign len   = LEN_W'(2) << expo;
  assign pulse = left_q != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (fire)   left_q <= len;
    else if (pulse)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import kwd_pkg::*;
#(
  parameter int RELOAD_SHIFT = 12,
  parameter int PRE_BASE     = 3,
  parameter int PRE_STEP     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [3:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        irq_o,
  output logic        rst_req_o
);
  localparam int CNT_W = FIELD_W + RELOAD_SHIFT;

  mode_t            mode_q;
  timing_t          time_q;
  logic             kick;
  logic             tick;
  logic             expired_q;
  logic             expire_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             wd_en;

  assign wd_en = mode_q.run;

  kwd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .expired(expired_q), .mode_q(mode_q), .time_q(time_q),
    .kick(kick), .prdata(prdata)
  );

  kwd_prescale #(.BASE_SHIFT(PRE_BASE), .STEP_SHIFT(PRE_STEP)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(wd_en), .clr(kick),
    .sel(time_q.psel), .tick(tick)
  );

  kwd_count #(.FIELD_W(FIELD_W), .SHIFT(RELOAD_SHIFT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(wd_en), .tick(tick), .kick(kick),
    .field(time_q.field), .cnt_q(cnt_q), .expired_q(expired_q),
    .expire_evt(expire_evt)
  );

  kwd_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire_evt && mode_q.req_en),
    .code(mode_q.pcode), .pulse(rst_req_o)
  );

  assign irq_o = expired_q & mode_q.irq_en;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [3:0]       paddr,
  input logic [31:0]      pwdata,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             wd_en,
  input logic             kick,
  input logic             expired,
  input logic [CNT_W-1:0] cnt
);
  logic [5:0] hi_run;
  logic       bad_mode_wr;
  logic       bad_kick_wr;

  assign bad_mode_wr = psel && penable && pwrite && paddr[3:2] == 2'd0
                       && pwdata[23:12] != 12'hABC;
  assign bad_kick_wr = psel && penable && pwrite && paddr[3:2] == 2'd2
                       && pwdata != 32'h0000_1999;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= '0;
    else if (rst_req_o) hi_run <= hi_run + 1'b1;
    else                hi_run <= '0;
  end

  assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode_wr |=> $stable(wd_en));

  assert_bad_kick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_kick_wr && expired) |=> expired);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !kick) |=> $stable(cnt));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !kick) |=> expired);

  assert_irq_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> expired);

  assert_pulse_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> expired);

  assert_pulse_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= 6'd16);
endmodule

bind keyed_wdog kwd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
  .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .irq_o(irq_o),
  .rst_req_o(rst_req_o), .wd_en(wd_en), .kick(kick),
  .expired(expired_q), .cnt(cnt_q)
);

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [3:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq_o, rst_req_o;

  int n_run = 0;
  int n_fail = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        rd_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdog #(.RELOAD_SHIFT(4)) u_keyed_wdog (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected read data when the driver fires
  always begin
    @(rd_ev);
    if (exp_q.size() == 0) begin
      chk("SB empty", 32'd1, 32'd0);
    end else begin
      chk(tag_q.pop_front(), prdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    #1;
    -> rd_ev;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: act=running exp=done");
    finish_up();
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 rst_req", {31'd0, rst_req_o}, 32'd0);
    rd(4'h0, 32'h0, "R1 mode");
    rd(4'h4, 32'h0000_3FFF, "R1 timing");
    rd(4'h8, 32'h0, "R1 kick");
    rd(4'hC, 32'h0, "R1 status");

    // R2 key gating of the mode register
    wr(4'h0, 32'h00AB_B007);
    rd(4'h0, 32'h0, "R2 bad key ignored");
    wr(4'h0, 32'h00AB_C037);
    rd(4'h0, 32'h0000_0037, "R2 readback");
    wr(4'h0, 32'h00AB_C000);

    // R3 key gating of the timing register
    wr(4'h4, 32'h0093_0009);
    rd(4'h4, 32'h0000_3FFF, "R3 bad key ignored");
    wr(4'h4, 32'h0092_0008);
    rd(4'h4, 32'h0000_0008, "R3 readback");

    // R5/R6 sel 0 (div 8), field 2 -> 32 counts -> 256 cycles; code 1 -> 4
    wr(4'h0, 32'h00AB_C017);
    wr(4'h8, 32'h0000_1999);
    wait_n(255);
    chk("R5 before expiry", {31'd0, irq_o}, 32'd0);
    wait_n(1);
    chk("R5 expiry edge", {31'd0, irq_o}, 32'd1);
    chk("R10 pulse start", {31'd0, rst_req_o}, 32'd1);
    wait_n(3);
    chk("R10 code1 last", {31'd0, rst_req_o}, 32'd1);
    wait_n(1);
    chk("R10 code1 end", {31'd0, rst_req_o}, 32'd0);
    rd(4'hC, 32'h1, "R8 status set");

    // R4 bad restart ignored, good restart clears
    wr(4'h8, 32'h0000_1998);
    rd(4'hC, 32'h1, "R4 bad kick status");
    chk("R8 irq held", {31'd0, irq_o}, 32'd1);
    wr(4'h8, 32'h0000_1999);
    rd(4'hC, 32'h0, "R8 cleared by kick");
    chk("R9 irq cleared", {31'd0, irq_o}, 32'd0);

    // R7 disable stops counting
    wr(4'h0, 32'h00AB_C016);
    wait_n(600);
    chk("R7 no expiry", {31'd0, irq_o}, 32'd0);
    rd(4'hC, 32'h0, "R7 status");

    // R6 sel 1 (div 64), field 1 -> 1024 cycles; code 0 -> 2; irq off
    wr(4'h4, 32'h0092_0005);
    wr(4'h0, 32'h00AB_C003);
    wr(4'h8, 32'h0000_1999);
    wait_n(1023);
    chk("R6 div64 before", {31'd0, rst_req_o}, 32'd0);
    wait_n(1);
    chk("R6 div64 edge", {31'd0, rst_req_o}, 32'd1);
    chk("R9 irq disabled", {31'd0, irq_o}, 32'd0);
    wait_n(1);
    chk("R10 code0 second", {31'd0, rst_req_o}, 32'd1);
    wait_n(1);
    chk("R10 code0 end", {31'd0, rst_req_o}, 32'd0);
    wait_n(50);
    chk("R10 single pulse", {31'd0, rst_req_o}, 32'd0);
    rd(4'hC, 32'h1, "R8 status div64");

    // R6 sel 2 (div 512), field 1 -> 8192 cycles; code 7 -> 16
    wr(4'h4, 32'h0092_0006);
    wr(4'h0, 32'h00AB_C077);
    rd(4'h0, 32'h0000_0077, "R2 code7 readback");
    wr(4'h8, 32'h0000_1999);
    wait_n(8191);
    chk("R6 div512 before", {31'd0, irq_o}, 32'd0);
    wait_n(1);
    chk("R6 div512 edge", {31'd0, irq_o}, 32'd1);
    wait_n(15);
    chk("R10 code7 last", {31'd0, rst_req_o}, 32'd1);
    wait_n(1);
    chk("R10 code7 end", {31'd0, rst_req_o}, 32'd0);

    // R11 no pulse with reset request disabled
    wr(4'h4, 32'h0092_0008);
    wr(4'h0, 32'h00AB_C005);
    rd(4'h4, 32'h0000_0008, "R3 readback 2");
    wr(4'h8, 32'h0000_1999);
    wait_n(256);
    chk("R11 irq", {31'd0, irq_o}, 32'd1);
    chk("R11 no pulse", {31'd0, rst_req_o}, 32'd0);

    // R12 restart on the expiry edge
    wr(4'h0, 32'h00AB_C007);
    wr(4'h8, 32'h0000_1999);
    wait_n(254);
    wr(4'h8, 32'h0000_1999);
    chk("R12 irq", {31'd0, irq_o}, 32'd0);
    chk("R12 pulse", {31'd0, rst_req_o}, 32'd0);
    wait_n(255);
    chk("R12 new period before", {31'd0, irq_o}, 32'd0);
    wait_n(1);
    chk("R12 new period edge", {31'd0, irq_o}, 32'd1);

    wait_n(2);
    finish_up();
  end
endmodule